// File: doc/BRIEF.md
# Three-Phase Fetch/Decode/Execute Core

This block is a very small stored-program processor. Code and data share one synchronous memory of 32 words, each 9 bits wide. Each instruction runs in three clock cycles. The first cycle reads the word at the program counter. The second captures that word as the current instruction and starts the operand read. The third updates the registers, the memory, the error flag and the program counter. The machine has two 9-bit data registers (A and B), a one-bit error flag and a 5-bit program counter.

The instruction set has five operations:
- Load a register from memory.
- Store a register to memory.
- Subtract B from A. On underflow the result saturates to zero and the error flag is set.
- Jump to the operand address when the error flag is set.
- Stop.

Three opcode values are undefined. Fetching one halts the machine and raises an illegal-instruction output.

A test harness or host loads the program through a backdoor memory port while the core is stalled (run low) or halted. It raises `run` to start execution and reads memory back through the same port once `halted` is high.

Top module: `fde_core`

## Requirements
- R1: After reset, the program counter, A, B and the error flag are all zero, and `halted` and `illegal` are low. Execution therefore starts at address 0 and sees A = B = 0.
- R2: An instruction word holds three fields: the opcode in bits [8:6], the register select in bit [5] (0 = A, 1 = B), and the address operand in bits [4:0]. With `run` high, each instruction takes exactly three clock edges, so a STOP at address 0 raises `halted` on the third edge.
- R3: LOAD (opcode 010) copies the memory word at the operand address into the selected register and leaves the error flag at 0.
- R4: STORE (opcode 011) writes the selected register to the memory word at the operand address and leaves the error flag at 0. Code may overwrite itself, and the next fetch sees the new word.
- R5: SUB (opcode 101) ignores bits [5:0]. When A ≥ B (unsigned), it writes A−B into A and clears the flag. Otherwise it writes 0 into A and sets the flag to 1.
- R6: JE (opcode 110) loads the operand into the program counter when the flag is 1, and otherwise advances the program counter by one. In both cases the flag ends at 0.
- R7: STOP (opcode 111) ignores bits [5:0]. It raises `halted`, which stays high until reset, and causes no further memory writes.
- R8: Opcodes 000, 001 and 100 halt the machine with both `illegal` and `halted` high. No register or memory update follows.
- R9: Every instruction other than a taken JE advances the program counter by one, and the counter wraps from 31 to 0.
- R10: While `run` is low or `bd_en` is high, the sequencer holds its state. A backdoor write stores `bd_wdata` at `bd_addr`. A backdoor read presents the word on `bd_rdata` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Lets the sequencer advance |
| halted | output | 1 | High once a STOP or undefined opcode has executed |
| illegal | output | 1 | High when the halt came from an undefined opcode |
| bd_en | input | 1 | Backdoor takes the memory port this cycle |
| bd_we | input | 1 | Backdoor write when high, read when low |
| bd_addr | input | 5 | Backdoor word address |
| bd_wdata | input | 9 | Backdoor write data |
| bd_rdata | output | 9 | Registered memory read data |

## Verification
Three situations are hard to reach from the ports alone:
- A taken jump needs the error flag set, and only an underflowing subtract can set it. Every jump test therefore runs a program that first loads operands chosen to underflow (or not) and follows SUB directly with JE. The outcome is visible only through which address a later STORE writes.
- The check that JE and LOAD clear the flag uses a second JE or a LOAD that comes right after the flag was set.
- Reaching the counter wrap needs a taken jump to address 30. The code there stores a STOP word over address 0, so the wrap is proven by the machine halting cleanly on the rewritten word.

// File: rtl/fde_pkg.sv
package fde_pkg;

   localparam int OPC_W = 3;

   localparam logic [OPC_W-1:0] OPC_LOAD  = 3'b010;
   localparam logic [OPC_W-1:0] OPC_STORE = 3'b011;
   localparam logic [OPC_W-1:0] OPC_SUB   = 3'b101;
   localparam logic [OPC_W-1:0] OPC_JE    = 3'b110;
   localparam logic [OPC_W-1:0] OPC_STOP  = 3'b111;

   typedef enum logic [1:0] {
      ST_FETCH  = 2'd0,
      ST_DECODE = 2'd1,
      ST_EXEC   = 2'd2,
      ST_HALT   = 2'd3
   } fde_state_t;

   typedef enum logic [2:0] {
      K_LOAD  = 3'd0,
      K_STORE = 3'd1,
      K_SUB   = 3'd2,
      K_JE    = 3'd3,
      K_STOP  = 3'd4,
      K_BAD   = 3'd5
   } fde_kind_t;

endpackage

// File: rtl/fde_mem.sv
module fde_mem #(
   parameter int DATA_W = 9,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   initial begin : chk_depth
      assert (DEPTH <= 4096) else $fatal(1, "fde_mem: depth too large");
   end

   logic [DATA_W-1:0] words [DEPTH];

   // Read-before-write single port; array itself carries no reset.
   always_ff @(posedge clk) begin
      if (en && we) words[addr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (en) rdata <= words[addr];
   end

endmodule

// File: rtl/fde_decode.sv
module fde_decode
   import fde_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int ADDR_W = 5,
   parameter int SEL_W  = 1
) (
   input  logic [DATA_W-1:0] instr,
   output fde_kind_t         kind,
   output logic [SEL_W-1:0]  rsel,
   output logic [ADDR_W-1:0] opnd
);
   localparam int OPC_LSB = DATA_W - OPC_W;

   initial begin : chk_fields
      assert (OPC_W + SEL_W + ADDR_W <= DATA_W)
         else $fatal(1, "fde_decode: fields exceed word width");
   end

   logic [OPC_W-1:0] opc;

   assign opc  = instr[DATA_W-1 -: OPC_W];
   assign rsel = instr[OPC_LSB-1 -: SEL_W];
   assign opnd = instr[ADDR_W-1:0];

   always_comb begin
      unique case (opc)
         OPC_LOAD:  kind = K_LOAD;
         OPC_STORE: kind = K_STORE;
         OPC_SUB:   kind = K_SUB;
         OPC_JE:    kind = K_JE;
         OPC_STOP:  kind = K_STOP;
         default:   kind = K_BAD;
      endcase
   end

endmodule

// File: rtl/fde_regbank.sv
module fde_regbank #(
   parameter int W     = 9,
   parameter int SEL_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [SEL_W-1:0] wsel,
   input  logic [W-1:0]     wdata,
   input  logic [SEL_W-1:0] rsel,
   output logic [W-1:0]     rdata,
   output logic [W-1:0]     a_q,
   output logic [W-1:0]     b_q
);
   localparam int NUM = 1 << SEL_W;

   initial begin : chk_num
      assert (NUM >= 2) else $fatal(1, "fde_regbank: need at least two registers");
   end

   logic [NUM-1:0][W-1:0] regs;

   for (genvar g = 0; g < NUM; g++) begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                          q <= '0;
         else if (we && (wsel == SEL_W'(g))) q <= wdata;
      end
      assign regs[g] = q;
   end

   assign rdata = regs[rsel];
   assign a_q   = regs[0];
   assign b_q   = regs[1];

endmodule

// File: rtl/fde_sub.sv
module fde_sub #(
   parameter int W        = 9,
   parameter bit SATURATE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res,
   output logic         under
);
   logic [W-1:0] diff;

   assign under = (a < b);
   assign diff  = a - b;

   if (SATURATE) begin : g_sat
      assign res = under ? '0 : diff;
   end else begin : g_wrap
      assign res = diff;
   end

endmodule

// File: rtl/fde_core.sv
module fde_core
   import fde_pkg::*;
#(
   parameter int DATA_W   = 9,
   parameter int ADDR_W   = 5,
   parameter int SEL_W    = 1,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   output logic              halted,
   output logic              illegal,
   input  logic              bd_en,
   input  logic              bd_we,
   input  logic [ADDR_W-1:0] bd_addr,
   input  logic [DATA_W-1:0] bd_wdata,
   output logic [DATA_W-1:0] bd_rdata
);
   initial begin : chk_params
      assert (DATA_W >= OPC_W + SEL_W + ADDR_W) else $fatal(1, "fde_core: word too narrow");
      assert (ADDR_W >= 1) else $fatal(1, "fde_core: address width");
   end

   fde_state_t        state;
   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] ir;
   logic              err;
   logic              ill_q;
   logic              adv;
   logic              in_exec;

   fde_kind_t         kind;
   logic [SEL_W-1:0]  rsel;
   logic [ADDR_W-1:0] opnd;

   logic              m_en, m_we;
   logic [ADDR_W-1:0] m_addr;
   logic [DATA_W-1:0] m_wdata, m_rdata;

   logic              r_we;
   logic [SEL_W-1:0]  r_wsel;
   logic [DATA_W-1:0] r_wdata, r_sel_q, a_val, b_val;

   logic [DATA_W-1:0] sub_res;
   logic              sub_under;

   assign adv     = run && !bd_en && (state != ST_HALT);
   assign in_exec = adv && (state == ST_EXEC);

   fde_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dec (
      .instr(ir), .kind(kind), .rsel(rsel), .opnd(opnd)
   );

   // Memory port: backdoor has priority; core addresses by phase.
   always_comb begin
      if (bd_en) begin
         m_addr  = bd_addr;
         m_we    = bd_we;
         m_wdata = bd_wdata;
      end else begin
         unique case (state)
            ST_FETCH:  m_addr = pc;
            ST_DECODE: m_addr = m_rdata[ADDR_W-1:0];
            default:   m_addr = opnd;
         endcase
         m_we    = in_exec && (kind == K_STORE);
         m_wdata = r_sel_q;
      end
   end
   assign m_en = bd_en || adv;

   fde_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .en(m_en), .we(m_we),
      .addr(m_addr), .wdata(m_wdata), .rdata(m_rdata)
   );

   assign r_we    = in_exec && ((kind == K_LOAD) || (kind == K_SUB));
   assign r_wsel  = (kind == K_LOAD) ? rsel : '0;
   assign r_wdata = (kind == K_LOAD) ? m_rdata : sub_res;

   fde_regbank #(.W(DATA_W), .SEL_W(SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(r_we), .wsel(r_wsel), .wdata(r_wdata),
      .rsel(rsel), .rdata(r_sel_q), .a_q(a_val), .b_q(b_val)
   );

   fde_sub #(.W(DATA_W), .SATURATE(SATURATE)) u_sub (
      .a(a_val), .b(b_val), .res(sub_res), .under(sub_under)
   );

   // Sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_FETCH;
         pc    <= '0;
         ir    <= '0;
         err   <= 1'b0;
         ill_q <= 1'b0;
      end else if (adv) begin
         unique case (state)
            ST_FETCH:  state <= ST_DECODE;
            ST_DECODE: begin
               ir    <= m_rdata;
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               err <= (kind == K_SUB) ? sub_under : 1'b0;
               unique case (kind)
                  K_STOP: state <= ST_HALT;
                  K_BAD: begin
                     state <= ST_HALT;
                     ill_q <= 1'b1;
                  end
                  K_JE: begin
                     pc    <= err ? opnd : pc + ADDR_W'(1);
                     state <= ST_FETCH;
                  end
                  default: begin
                     pc    <= pc + ADDR_W'(1);
                     state <= ST_FETCH;
                  end
               endcase
            end
            default: state <= ST_HALT;
         endcase
      end
   end

   assign halted   = (state == ST_HALT);
   assign illegal  = ill_q;
   assign bd_rdata = m_rdata;

   // Checks next to the sequencer
   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R7
   AST_ILLEGAL_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> halted); // R8
   AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && (kind != K_SUB)) |=> !err); // R3
   AST_SUB_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && (kind == K_SUB) && (a_val < b_val)) |=> ((a_val == '0) && err)); // R5
   AST_JE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && (kind == K_JE) && err) |=> (pc == $past(opnd))); // R6
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && ((kind == K_LOAD) || (kind == K_STORE) || (kind == K_SUB)))
      |=> (pc == $past(pc) + ADDR_W'(1))); // R9
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !halted) |=> $stable(state)); // R10

endmodule

// File: tb/sim_fde_core.sv
module sim_fde_core;
   localparam int CLK_P = 10;
   localparam logic [8:0] SENT = 9'h1AA;

   logic       clk = 1'b0;
   logic       rst_n, run, bd_en, bd_we;
   logic [4:0] bd_addr;
   logic [8:0] bd_wdata, bd_rdata;
   logic       halted, illegal;

   int checks = 0;
   int errors = 0;
   logic [8:0] img [32];

   always #(CLK_P/2) clk = ~clk;

   fde_core u0 (
      .clk(clk), .rst_n(rst_n), .run(run), .halted(halted), .illegal(illegal),
      .bd_en(bd_en), .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata),
      .bd_rdata(bd_rdata)
   );

   function automatic logic [8:0] ins(input logic [2:0] op, input logic s, input logic [4:0] a);
      return {op, s, a};
   endfunction

   function automatic logic [8:0] val(input int i);
      if (i == 0) return 9'd0;
      if (i == 1) return 9'd1;
      if (i == 2) return 9'd511;
      return 9'((i * 97 + 13) % 512);
   endfunction

   task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; run = 1'b0; bd_en = 1'b0; bd_we = 1'b0;
      bd_addr = '0; bd_wdata = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic mem_wr(input logic [4:0] a, input logic [8:0] d);
      bd_en = 1'b1; bd_we = 1'b1; bd_addr = a; bd_wdata = d;
      @(negedge clk);
      bd_en = 1'b0; bd_we = 1'b0;
   endtask

   task automatic mem_rd(input logic [4:0] a, output logic [8:0] d);
      bd_en = 1'b1; bd_we = 1'b0; bd_addr = a;
      @(negedge clk);
      d = bd_rdata;
      bd_en = 1'b0;
   endtask

   task automatic clear_img();
      for (int k = 0; k < 32; k++) img[k] = 9'd0;
      img[22] = SENT; img[23] = SENT; img[24] = SENT;
   endtask

   task automatic load_img();
      for (int k = 0; k < 32; k++) mem_wr(5'(k), img[k]);
   endtask

   task automatic run_prog(input string tag);
      int n;
      n = 0;
      run = 1'b1;
      while (!halted && n < 300) begin
         @(negedge clk);
         n++;
      end
      run = 1'b0;
      chk({tag, " halted"}, {8'd0, halted}, 9'd1);
   endtask

   initial begin : watchdog
      #(CLK_P * 150000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [8:0] d, va, vb;
      @(negedge clk);
      do_reset();

      // R1 outputs after reset
      chk("R1 halted after reset", {8'd0, halted}, 9'd0);
      chk("R1 illegal after reset", {8'd0, illegal}, 9'd0);

      // R10 backdoor write/read
      mem_wr(5'd9, 9'h155);
      mem_rd(5'd9, d);
      chk("R10 backdoor readback", d, 9'h155);

      // R2 / R10: STOP at 0, stall then exactly three edges
      clear_img();
      img[0] = ins(3'b111, 1'b1, 5'b10101);
      load_img();
      repeat (5) @(negedge clk);
      chk("R10 stalled while run low", {8'd0, halted}, 9'd0);
      run = 1'b1;
      repeat (2) @(negedge clk);
      chk("R2 not halted after two edges", {8'd0, halted}, 9'd0);
      @(negedge clk);
      chk("R2 halted on third edge", {8'd0, halted}, 9'd1);
      chk("R7 stop is not illegal", {8'd0, illegal}, 9'd0);
      run = 1'b0;

      // R5 / R6 / R3 / R4 sweep over operand pairs
      for (int i = 0; i < 12; i++) begin
         for (int j = 0; j < 12; j++) begin
            va = val(i); vb = val(j);
            clear_img();
            img[0]  = ins(3'b010, 1'b0, 5'd20);
            img[1]  = ins(3'b010, 1'b1, 5'd21);
            img[2]  = {3'b101, 6'((i * 5 + j) % 64)};
            img[3]  = ins(3'b110, 1'b0, 5'd7);
            img[4]  = ins(3'b011, 1'b0, 5'd22);
            img[5]  = ins(3'b011, 1'b1, 5'd24);
            img[6]  = ins(3'b111, 1'b0, 5'd0);
            img[7]  = ins(3'b011, 1'b0, 5'd23);
            img[8]  = ins(3'b111, 1'b1, 5'b10101);
            img[20] = va; img[21] = vb;
            do_reset();
            load_img();
            run_prog("R7 sweep");
            mem_rd(5'd22, d);
            chk("R5 difference store", d, (va >= vb) ? va - vb : SENT);
            mem_rd(5'd23, d);
            chk("R6 jump on underflow", d, (va >= vb) ? SENT : 9'd0);
            mem_rd(5'd24, d);
            chk("R4 store B after load", d, (va >= vb) ? vb : SENT);
            chk("R8 sweep not illegal", {8'd0, illegal}, 9'd0);
         end
      end

      // R6: JE clears the flag, so a second JE falls through
      clear_img();
      img[0] = ins(3'b010, 1'b0, 5'd20);
      img[1] = ins(3'b010, 1'b1, 5'd21);
      img[2] = {3'b101, 6'd0};
      img[3] = ins(3'b110, 1'b0, 5'd5);
      img[4] = ins(3'b111, 1'b0, 5'd0);
      img[5] = ins(3'b110, 1'b0, 5'd8);
      img[6] = ins(3'b010, 1'b0, 5'd21);
      img[7] = ins(3'b011, 1'b0, 5'd22);
      img[8] = ins(3'b111, 1'b0, 5'd0);
      img[20] = 9'd0; img[21] = 9'd1;
      do_reset(); load_img(); run_prog("R6 clear");
      mem_rd(5'd22, d);
      chk("R6 flag cleared by JE", d, 9'd1);

      // R3: LOAD clears the flag
      clear_img();
      img[0] = ins(3'b010, 1'b0, 5'd20);
      img[1] = ins(3'b010, 1'b1, 5'd21);
      img[2] = {3'b101, 6'd0};
      img[3] = ins(3'b010, 1'b0, 5'd21);
      img[4] = ins(3'b110, 1'b0, 5'd7);
      img[5] = ins(3'b011, 1'b0, 5'd22);
      img[6] = ins(3'b111, 1'b0, 5'd0);
      img[7] = ins(3'b111, 1'b0, 5'd0);
      img[20] = 9'd0; img[21] = 9'd1;
      do_reset(); load_img(); run_prog("R3 clear");
      mem_rd(5'd22, d);
      chk("R3 flag cleared by LOAD", d, 9'd1);

      // R1: registers zero after reset (previous run left A = 1)
      clear_img();
      img[0] = ins(3'b011, 1'b0, 5'd22);
      img[1] = ins(3'b011, 1'b1, 5'd23);
      img[2] = ins(3'b111, 1'b0, 5'd0);
      do_reset(); load_img(); run_prog("R1 regs");
      mem_rd(5'd22, d);
      chk("R1 A zero after reset", d, 9'd0);
      mem_rd(5'd23, d);
      chk("R1 B zero after reset", d, 9'd0);

      // R9 / R4: jump to 30, overwrite address 0 with STOP, wrap to 0
      clear_img();
      img[0]  = ins(3'b010, 1'b0, 5'd20);
      img[1]  = ins(3'b010, 1'b1, 5'd21);
      img[2]  = {3'b101, 6'd0};
      img[3]  = ins(3'b110, 1'b0, 5'd30);
      img[25] = ins(3'b111, 1'b0, 5'd0);
      img[30] = ins(3'b010, 1'b1, 5'd25);
      img[31] = ins(3'b011, 1'b1, 5'd0);
      img[20] = 9'd0; img[21] = 9'd1;
      do_reset(); load_img(); run_prog("R9 wrap");
      chk("R9 wrap not illegal", {8'd0, illegal}, 9'd0);
      mem_rd(5'd0, d);
      chk("R4 self-modifying store", d, 9'h1C0);

      // R8: undefined opcodes
      for (int k = 0; k < 3; k++) begin
         logic [2:0] op;
         op = (k == 0) ? 3'b000 : (k == 1) ? 3'b001 : 3'b100;
         clear_img();
         img[0] = {op, 6'b101010};
         img[1] = ins(3'b011, 1'b0, 5'd22);
         do_reset(); load_img(); run_prog("R8 bad");
         chk("R8 illegal raised", {8'd0, illegal}, 9'd1);
         mem_rd(5'd22, d);
         chk("R8 no store after bad op", d, SENT);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule